// File: doc/BRIEF.md
# Mode-Dependent Address Decoder with Vector Remap

This block turns the 16-bit address of an 8-bit microcontroller bus into one-hot chip selects for the internal RAM, the register and I/O window, the internal ROM, a small boot ROM and the external bus. Its memory map depends on an operating mode. The mode is captured from two mode pins while reset is held. After reset the captured mode does not change until the next reset.

In bootstrap and test modes the block rewrites the address of a vector fetch. It clears address bit 14, so a vector that would come from the top page is taken from the alternate page just below 0xC000. It then decodes the rewritten address. In bootstrap mode this lands in the boot ROM. In test mode the boot ROM is switched off, so the fetch goes to external memory. The rewritten address is also driven out, so that the memories and the external bus see the same address that was decoded.

Top module: `mode_addr_decoder`

## Requirements
- R1: The mode is sampled from `mode_pins_i` on every clock edge while `rst_n` is low. It keeps that value once `rst_n` is high, whatever the pins do afterwards. The encoding is 2'b00 bootstrap, 2'b01 single-chip, 2'b10 test and 2'b11 expanded.
- R2: In every mode, an effective address in 0x0000–0x01FF selects RAM.
- R3: In every mode, an effective address in 0x1000–0x107F selects the register window.
- R4: In single-chip, bootstrap and test modes, an effective address in 0xC000–0xFFFF selects the internal ROM.
- R5: In expanded mode, effective addresses 0xC000–0xFFFF select the external bus and never the internal ROM.
- R6: In bootstrap mode, effective addresses 0xBF00–0xBFFF select the boot ROM. In every other mode that range goes to the external bus.
- R7: When `vec_fetch_i` is high in bootstrap or test mode, bit 14 of `eff_addr_o` is 0 and the other bits copy `addr_i`. Decoding uses this effective address.
- R8: When `vec_fetch_i` is low, or the mode is single-chip or expanded, `eff_addr_o` equals `addr_i`.
- R9: `sel_o` always has exactly one bit set. The bit positions are [0] register window, [1] RAM, [2] boot ROM, [3] ROM and [4] external. When regions overlap, the priority is register window, then RAM, then boot ROM, then ROM.
- R10: An effective address that no enabled internal region claims selects the external bus.
- R11: In test mode, a vector fetch at 0xFFFE gives effective address 0xBFFE and selects the external bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Active-low reset; while low, the mode pins are captured |
| mode_pins_i | input | 2 | Mode pins, sampled only during reset |
| addr_i | input | 16 | Bus address from the CPU |
| vec_fetch_i | input | 1 | High when the current access is a vector fetch |
| eff_addr_o | output | 16 | Effective address after any vector remap |
| sel_o | output | 5 | One-hot select: [0] reg, [1] RAM, [2] boot, [3] ROM, [4] external |

## Verification
The bench probes the first and last byte of every region, and the byte just past each region. A comparison that is off by one would then send the edge byte to the wrong target, or leave it on the external bus. It runs vector fetches in all four modes:
- A remap applied in single-chip or expanded mode shows up as a changed effective address.
- Enabling the boot ROM in test mode would claim the fetch at 0xBFFE that belongs to the external bus.

Vector fetches at 0x4000 and 0x5000 in bootstrap mode check that decoding uses the rewritten address, landing in RAM and in the register window. Changing the mode pins after reset would show as a changed decode if the latch kept following them.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    typedef enum logic [1:0] {
        MODE_BOOT   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_TEST   = 2'b10,
        MODE_EXPAND = 2'b11
    } op_mode_e;

    localparam int SEL_N    = 5;
    localparam int SEL_REG  = 0;
    localparam int SEL_RAM  = 1;
    localparam int SEL_BOOT = 2;
    localparam int SEL_ROM  = 3;
    localparam int SEL_EXT  = 4;

    typedef struct packed {
        op_mode_e mode;
    } latch_st_t;

endpackage

// File: rtl/mode_latch.sv
module mode_latch
    import addr_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic [1:0] mode_pins_i,
    output op_mode_e mode_o
);

    latch_st_t st_d;
    latch_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode = op_mode_e'(mode_pins_i);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/vec_remap.sv
module vec_remap
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REMAP_BIT = 14
) (
    input  op_mode_e          mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              vec_fetch_i,
    output logic [ADDR_W-1:0] eff_addr_o
);

    logic remap_mode;

    always_comb begin
        remap_mode = (mode_i == MODE_BOOT) || (mode_i == MODE_TEST);
        eff_addr_o = addr_i;
        if (vec_fetch_i && remap_mode) begin
            eff_addr_o[REMAP_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/region_decode.sv
module region_decode
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REG_BASE  = 'h1000,
    parameter int REG_SIZE  = 'h0080,
    parameter int RAM_BASE  = 'h0000,
    parameter int RAM_SIZE  = 'h0200,
    parameter int BOOT_BASE = 'hBF00,
    parameter int BOOT_SIZE = 'h0100,
    parameter int ROM_BASE  = 'hC000,
    parameter int ROM_SIZE  = 'h4000
) (
    input  op_mode_e          mode_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    output logic [SEL_N-1:0]  sel_o
);

    localparam int N_INT = 4;
    localparam int unsigned LO [N_INT] = '{REG_BASE, RAM_BASE, BOOT_BASE, ROM_BASE};
    localparam int unsigned HI [N_INT] = '{REG_BASE + REG_SIZE, RAM_BASE + RAM_SIZE,
                                           BOOT_BASE + BOOT_SIZE, ROM_BASE + ROM_SIZE};

    logic [31:0]      addr_w;
    logic [N_INT-1:0] hit;
    logic [N_INT-1:0] en;

    assign addr_w = 32'(eff_addr_i);

    for (genvar g = 0; g < N_INT; g++) begin : g_hit
        assign hit[g] = (addr_w >= LO[g]) && (addr_w < HI[g]);
    end

    always_comb begin
        en           = '1;
        en[SEL_BOOT] = (mode_i == MODE_BOOT);
        en[SEL_ROM]  = (mode_i != MODE_EXPAND);
    end

    always_comb begin
        logic taken;
        taken = 1'b0;
        sel_o = '0;
        for (int i = 0; i < N_INT; i++) begin
            if (!taken && hit[i] && en[i]) begin
                sel_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        if (!taken) begin
            sel_o[SEL_EXT] = 1'b1;
        end
    end

endmodule

// File: rtl/mode_addr_decoder.sv
module mode_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REMAP_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_pins_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              vec_fetch_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic [SEL_N-1:0]  sel_o
);

    op_mode_e mode_w;

    mode_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pins_i (mode_pins_i),
        .mode_o      (mode_w)
    );

    vec_remap #(
        .ADDR_W    (ADDR_W),
        .REMAP_BIT (REMAP_BIT)
    ) u_remap (
        .mode_i      (mode_w),
        .addr_i      (addr_i),
        .vec_fetch_i (vec_fetch_i),
        .eff_addr_o  (eff_addr_o)
    );

    region_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .mode_i     (mode_w),
        .eff_addr_i (eff_addr_o),
        .sel_o      (sel_o)
    );

endmodule

// File: rtl/mode_addr_decoder_chk.sv
module mode_addr_decoder_chk
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REMAP_BIT = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_q,
    input logic [ADDR_W-1:0] addr_i,
    input logic              vec_fetch_i,
    input logic [ADDR_W-1:0] eff_addr_o,
    input logic [SEL_N-1:0]  sel_o
);

    logic remap_on;
    assign remap_on = vec_fetch_i && ((mode_q == 2'b00) || (mode_q == 2'b10));

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    p_no_rom_expanded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b11) |-> !sel_o[SEL_ROM]);

    p_boot_only_bootstrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b00) |-> !sel_o[SEL_BOOT]);

    p_remap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        remap_on |-> (eff_addr_o[REMAP_BIT] == 1'b0));

    p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_on |-> (eff_addr_o == addr_i));

    p_one_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1);

endmodule

bind mode_addr_decoder mode_addr_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .REMAP_BIT (REMAP_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_w),
    .addr_i      (addr_i),
    .vec_fetch_i (vec_fetch_i),
    .eff_addr_o  (eff_addr_o),
    .sel_o       (sel_o)
);

// File: tb/tb_mode_addr_decoder.sv
module tb_mode_addr_decoder;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [4:0] S_REG  = 5'b00001;
    localparam logic [4:0] S_RAM  = 5'b00010;
    localparam logic [4:0] S_BOOT = 5'b00100;
    localparam logic [4:0] S_ROM  = 5'b01000;
    localparam logic [4:0] S_EXT  = 5'b10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = 2'b01;
    logic [15:0] addr = 16'h0000;
    logic        vf = 1'b0;
    logic [15:0] eff;
    logic [4:0]  sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mode_addr_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pins_i (mode_pins),
        .addr_i      (addr),
        .vec_fetch_i (vf),
        .eff_addr_o  (eff),
        .sel_o       (sel)
    );

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n     = 1'b0;
        mode_pins = m;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        @(negedge clk);
        mode_pins = ~m;
        repeat (2) @(negedge clk);
    endtask

    task automatic check(input logic [15:0] a, input logic v,
                         input logic [15:0] exp_eff, input logic [4:0] exp_sel,
                         input string tag);
        @(negedge clk);
        addr = a;
        vf   = v;
        #1;
        n_checks++;
        if (sel !== exp_sel || eff !== exp_eff) begin
            n_fail++;
            $display("FAIL %s addr=%h vf=%0b: sel=%b eff=%h, expected sel=%b eff=%h",
                     tag, a, v, sel, eff, exp_sel, exp_eff);
        end
    endtask

    task automatic test_reset_state();
        do_reset(2'b01);
        check(16'h0000, 1'b0, 16'h0000, S_RAM, "R1 reset state single-chip RAM");
        check(16'hC000, 1'b0, 16'hC000, S_ROM, "R1 mode held after pins change");
    endtask

    task automatic test_single();
        do_reset(2'b01);
        check(16'h01FF, 1'b0, 16'h01FF, S_RAM, "R2 RAM top");
        check(16'h0200, 1'b0, 16'h0200, S_EXT, "R10 past RAM");
        check(16'h1000, 1'b0, 16'h1000, S_REG, "R3 reg base");
        check(16'h107F, 1'b0, 16'h107F, S_REG, "R3 reg top");
        check(16'h1080, 1'b0, 16'h1080, S_EXT, "R10 past reg");
        check(16'hBF00, 1'b0, 16'hBF00, S_EXT, "R6 boot off in single");
        check(16'hFFFF, 1'b0, 16'hFFFF, S_ROM, "R4 ROM top single");
        check(16'hFFFE, 1'b1, 16'hFFFE, S_ROM, "R8 no remap single");
        check(16'h8000, 1'b0, 16'h8000, S_EXT, "R10 gap R9 one-hot");
    endtask

    task automatic test_boot();
        do_reset(2'b00);
        check(16'hBF00, 1'b0, 16'hBF00, S_BOOT, "R6 boot base");
        check(16'hBFFF, 1'b0, 16'hBFFF, S_BOOT, "R6 boot top");
        check(16'hBEFF, 1'b0, 16'hBEFF, S_EXT,  "R10 below boot");
        check(16'hFFFE, 1'b1, 16'hBFFE, S_BOOT, "R7 vector to boot");
        check(16'hFFFE, 1'b0, 16'hFFFE, S_ROM,  "R8 plain read ROM boot");
        check(16'hC000, 1'b0, 16'hC000, S_ROM,  "R4 ROM base boot");
        check(16'h4000, 1'b1, 16'h0000, S_RAM,  "R7 remap into RAM");
        check(16'h5000, 1'b1, 16'h1000, S_REG,  "R7 remap into reg");
    endtask

    task automatic test_test_mode();
        do_reset(2'b10);
        check(16'hFFFE, 1'b1, 16'hBFFE, S_EXT, "R11 test vector external");
        check(16'hBFC0, 1'b0, 16'hBFC0, S_EXT, "R6 boot off in test");
        check(16'hC000, 1'b0, 16'hC000, S_ROM, "R4 ROM in test");
        check(16'h1040, 1'b0, 16'h1040, S_REG, "R3 reg in test");
    endtask

    task automatic test_expanded();
        do_reset(2'b11);
        check(16'hC000, 1'b0, 16'hC000, S_EXT, "R5 ROM off expanded");
        check(16'hFFFF, 1'b1, 16'hFFFF, S_EXT, "R8 R5 no remap expanded");
        check(16'h01FF, 1'b0, 16'h01FF, S_RAM, "R2 RAM expanded");
        check(16'h1000, 1'b0, 16'h1000, S_REG, "R3 reg expanded");
        check(16'hBF80, 1'b0, 16'hBF80, S_EXT, "R6 boot off expanded");
    endtask

    initial begin
        test_reset_state();
        test_single();
        test_boot();
        test_test_mode();
        test_expanded();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule